// File: doc/BRIEF.md
# Caption Line Pulse Generator

This block watches the line and field timing of a video stream and marks the one scan line per field that carries a caption word. It counts line-rate ticks from each vertical sync. When the count reaches the caption line that the selected mode asks for, and the current field is eligible, it raises a line pulse for exactly one line period. When that pulse ends, it issues a single-cycle capture strobe so that the caption word buffer can latch the word. A field flag goes out with the pulse, and the host reads that flag at the falling edge of the pulse to tell which field the word came from.

A two-bit mode input selects the caption line (21 or 22), the eligible fields (even only, or both), and the line-rate timing source. The timing source is either the horizontal sync input or an oscillator tick divided by a parameter (32 by default). In the oscillator mode the field flag is not driven, because that output serves the oscillator. The divided reference is brought out as its own output.

Top module: `cc_line_pulse_gen`

## Requirements
- R1: With mode 00 or 01, the line pulse appears only in even fields (parity input 1 latched at vertical sync) and only on line 21. Odd fields give no pulse.
- R2: With mode 10, the line pulse appears on line 21 of every field, odd or even.
- R3: With mode 11, the line pulse appears on line 22 of every field, odd or even, and never on line 21.
- R4: A vertical sync sets the line count to 1. Each line tick then adds one. If a vertical sync and a line tick arrive in the same cycle, the count becomes 1. After reset the count sits at its maximum, so no pulse can appear before the first vertical sync.
- R5: The line pulse rises on the tick that brings the count to the target line. It stays high until the next tick or vertical sync, so it is high for exactly one line of each field.
- R6: The capture strobe is high for exactly one clock, in the first cycle in which the line pulse is low after being high.
- R7: In modes 00, 10 and 11, the field flag gives the parity latched at the last vertical sync (1 = even). In mode 01 it is held at 0.
- R8: The field flag does not change in the cycle in which the line pulse falls, even when a vertical sync with the other parity ends the pulse. The new parity appears one cycle later.
- R9: In mode 01, lines are counted from the reference output, which pulses for one cycle after every 32nd oscillator tick, and the horizontal sync input is ignored. In the other modes, the divider is held cleared and the reference output stays 0.
- R10: The line count saturates at MAX_LINE (default 1023). Without a vertical sync, any number of further ticks never brings the count back to the caption line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode select: 00, 01, 10, 11 |
| vsync_i | input | 1 | One-cycle vertical sync pulse |
| hsync_i | input | 1 | One-cycle horizontal sync pulse |
| field_even_i | input | 1 | Field parity, 1 = even; sampled with vsync_i |
| osc_tick_i | input | 1 | One-cycle oscillator tick |
| line_pulse_o | output | 1 | High for the whole caption line |
| field_flag_o | output | 1 | Parity of the current field (0 in mode 01) |
| capture_o | output | 1 | One-cycle strobe at the fall of line_pulse_o |
| ref_tick_o | output | 1 | Divided oscillator reference (mode 01 only) |

## Verification
Two events can land in the same cycle. The first case is a vertical sync arriving together with a line tick. The bench drives both at once after line 20 and checks that counting starts again from 1, so the pulse comes exactly 20 ticks later. The second case is a vertical sync of the opposite parity arriving while the line pulse is high. The bench expects the pulse to drop, the capture strobe to fire and the old field flag to be held, all in that one cycle, with the new parity appearing on the next cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;
   typedef enum logic [1:0] {
      MODE_VCR_HS  = 2'b00,
      MODE_VCR_OSC = 2'b01,
      MODE_TV_21   = 2'b10,
      MODE_TV_22   = 2'b11
   } cap_mode_e;

   function automatic logic even_only(input cap_mode_e m);
      return (m == MODE_VCR_HS) || (m == MODE_VCR_OSC);
   endfunction
endpackage

// File: rtl/cc_ref_div.sv
module cc_ref_div #(
   parameter int DIV_RATIO = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic osc_tick,
   output logic ref_tick
);
   localparam int CW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
   localparam bit POW2 = (DIV_RATIO & (DIV_RATIO - 1)) == 0;

   if (DIV_RATIO < 2) begin : g_bad_ratio
      $error("cc_ref_div: DIV_RATIO must be at least 2");
   end

   logic [CW-1:0] cnt_q, cnt_nxt;
   logic          last;
   logic          ref_q;

   if (POW2) begin : g_pow2
      assign last    = &cnt_q;
      assign cnt_nxt = cnt_q + 1'b1;
   end else begin : g_any
      assign last    = (cnt_q == CW'(DIV_RATIO - 1));
      assign cnt_nxt = last ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ref_q <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         ref_q <= 1'b0;
      end else begin
         ref_q <= 1'b0;
         if (osc_tick) begin
            cnt_q <= cnt_nxt;
            ref_q <= last;
         end
      end
   end

   assign ref_tick = ref_q;

   AST_REF_FROM_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      ref_q |-> $past(osc_tick && en)); // R9
   AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_q |=> !ref_q); // R9
endmodule

// File: rtl/cc_line_cnt.sv
module cc_line_cnt #(
   parameter int MAX_LINE = 1023,
   localparam int CW = $clog2(MAX_LINE + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vsync,
   input  logic          tick,
   output logic [CW-1:0] line
);
   if (MAX_LINE < 2) begin : g_bad_max
      $error("cc_line_cnt: MAX_LINE must be at least 2");
   end

   localparam logic [CW-1:0] TOP = CW'(MAX_LINE);

   logic [CW-1:0] line_q;
   logic          at_top;

   assign at_top = (line_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               line_q <= TOP;
      else if (vsync)           line_q <= CW'(1);
      else if (tick && !at_top) line_q <= line_q + 1'b1;
   end

   assign line = line_q;

   AST_VSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> (line_q == CW'(1))); // R4
   AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !vsync && !at_top) |=> (line_q == $past(line_q) + 1'b1)); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (at_top && !vsync) |=> at_top); // R10
endmodule

// File: rtl/cc_pulse_ctrl.sv
module cc_pulse_ctrl
   import cc_pkg::*;
#(
   parameter int LINE_STD = 21,
   parameter int LINE_ALT = 22,
   parameter int CW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cap_mode_e     mode,
   input  logic          vsync,
   input  logic          field_even,
   input  logic [CW-1:0] line,
   output logic          line_pulse,
   output logic          field_flag,
   output logic          capture
);
   if (LINE_STD < 2 || LINE_ALT < 2) begin : g_bad_line
      $error("cc_pulse_ctrl: caption lines must follow line 1");
   end
   if (LINE_STD >= (1 << CW) || LINE_ALT >= (1 << CW)) begin : g_bad_width
      $error("cc_pulse_ctrl: caption line does not fit the counter");
   end

   logic          field_q;
   logic          field_out_q;
   logic          pulse_prev_q;
   logic [CW-1:0] target;
   logic          eligible;

   always_comb begin
      unique case (mode)
         MODE_TV_22: target = CW'(LINE_ALT);
         default:    target = CW'(LINE_STD);
      endcase
      eligible = even_only(mode) ? field_q : 1'b1;
   end

   assign line_pulse = (line == target) && eligible;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q      <= 1'b0;
         field_out_q  <= 1'b0;
         pulse_prev_q <= 1'b0;
      end else begin
         if (vsync) field_q <= field_even;
         if (!line_pulse) field_out_q <= field_q;
         pulse_prev_q <= line_pulse;
      end
   end

   assign capture    = pulse_prev_q && !line_pulse;
   assign field_flag = (mode == MODE_VCR_OSC) ? 1'b0 : field_out_q;

   AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !capture); // R6
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(line_pulse) && $stable(mode)) |-> $stable(field_flag)); // R8
   AST_EVEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (line_pulse && even_only(mode) && $stable(mode) && !$past(vsync)) |-> field_q); // R1
endmodule

// File: rtl/cc_line_pulse_gen.sv
module cc_line_pulse_gen
   import cc_pkg::*;
#(
   parameter int DIV_RATIO = 32,
   parameter int MAX_LINE  = 1023,
   parameter int LINE_STD  = 21,
   parameter int LINE_ALT  = 22
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       vsync_i,
   input  logic       hsync_i,
   input  logic       field_even_i,
   input  logic       osc_tick_i,
   output logic       line_pulse_o,
   output logic       field_flag_o,
   output logic       capture_o,
   output logic       ref_tick_o
);
   localparam int CW = $clog2(MAX_LINE + 1);

   if (LINE_STD >= MAX_LINE || LINE_ALT >= MAX_LINE) begin : g_bad_cfg
      $error("cc_line_pulse_gen: caption lines must lie below MAX_LINE");
   end

   cap_mode_e     mode;
   logic          osc_mode;
   logic          ref_tick;
   logic          line_tick;
   logic [CW-1:0] line;

   assign mode      = cap_mode_e'(mode_i);
   assign osc_mode  = (mode == MODE_VCR_OSC);
   assign line_tick = osc_mode ? ref_tick : hsync_i;

   cc_ref_div #(.DIV_RATIO(DIV_RATIO)) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (osc_mode),
      .osc_tick (osc_tick_i),
      .ref_tick (ref_tick)
   );

   cc_line_cnt #(.MAX_LINE(MAX_LINE)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .vsync (vsync_i),
      .tick  (line_tick),
      .line  (line)
   );

   cc_pulse_ctrl #(.LINE_STD(LINE_STD), .LINE_ALT(LINE_ALT), .CW(CW)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .vsync      (vsync_i),
      .field_even (field_even_i),
      .line       (line),
      .line_pulse (line_pulse_o),
      .field_flag (field_flag_o),
      .capture    (capture_o)
   );

   assign ref_tick_o = ref_tick;

   AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(line_pulse_o) && $stable(mode_i)) |-> $past(line_tick || vsync_i)); // R5
   AST_REF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_mode && $past(!osc_mode)) |-> !ref_tick_o); // R9
endmodule

// File: tb/test_cc_line_pulse_gen.sv
`timescale 1ns/1ps
module test_cc_line_pulse_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_i = 2'b00;
   logic       vsync_i = 1'b0, hsync_i = 1'b0, field_even_i = 1'b0, osc_tick_i = 1'b0;
   logic       line_pulse_o, field_flag_o, capture_o, ref_tick_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cc_line_pulse_gen i_cc_line_pulse_gen (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .vsync_i(vsync_i),
      .hsync_i(hsync_i), .field_even_i(field_even_i), .osc_tick_i(osc_tick_i),
      .line_pulse_o(line_pulse_o), .field_flag_o(field_flag_o),
      .capture_o(capture_o), .ref_tick_o(ref_tick_o));

   // [7:6] mode, [5] field parity, [4:0] expected pulse line (0 = none)
   localparam logic [7:0] VEC [8] = '{
      {2'b00, 1'b1, 5'd21}, {2'b00, 1'b0, 5'd0},
      {2'b01, 1'b1, 5'd21}, {2'b01, 1'b0, 5'd0},
      {2'b10, 1'b1, 5'd21}, {2'b10, 1'b0, 5'd21},
      {2'b11, 1'b1, 5'd22}, {2'b11, 1'b0, 5'd22}};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_vsync(input logic par);
      vsync_i = 1'b1; field_even_i = par;
      @(negedge clk);
      vsync_i = 1'b0;
   endtask

   // one line of timing; returns number of ref pulses seen
   task automatic advance(output int refs);
      refs = 0;
      if (mode_i == 2'b01) begin
         hsync_i = 1'b1;  // ignored in this mode
         for (int k = 0; k < 32; k++) begin
            osc_tick_i = 1'b1;
            @(negedge clk);
            refs += int'(ref_tick_o);
         end
         osc_tick_i = 1'b0;
         @(negedge clk);
         refs += int'(ref_tick_o);
      end else begin
         osc_tick_i = 1'b1;  // divider must stay idle
         hsync_i = 1'b1;
         @(negedge clk);
         refs += int'(ref_tick_o);
      end
   endtask

   task automatic hs_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         hsync_i = 1'b1;
         @(negedge clk);
      end
      hsync_i = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      check(!line_pulse_o && !capture_o && !field_flag_o && !ref_tick_o, "R4 reset outputs",
            {line_pulse_o, capture_o, field_flag_o, ref_tick_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // no vsync yet: counter parked at maximum
      mode_i = 2'b10;
      begin
         int seen = 0;
         for (int k = 0; k < 30; k++) begin
            hsync_i = 1'b1; @(negedge clk);
            seen += int'(line_pulse_o);
         end
         hsync_i = 1'b0;
         check(seen == 0, "R4 no pulse before first vsync", seen, 0);
      end

      // vector table walk
      foreach (VEC[i]) begin
         logic [1:0] m;
         logic       par;
         int         expl, first, npulse, ncap, caplast, refsum, flagbad, r;
         string      rq;
         m = VEC[i][7:6]; par = VEC[i][5]; expl = int'(VEC[i][4:0]);
         first = 0; npulse = 0; ncap = 0; caplast = 0; refsum = 0; flagbad = 0;
         hsync_i = 1'b0; osc_tick_i = 1'b0;
         mode_i = m;
         @(negedge clk);
         do_vsync(par);
         for (int ln = 2; ln <= 26; ln++) begin
            advance(r);
            refsum += r;
            if (line_pulse_o) begin
               npulse++;
               if (first == 0) first = ln;
               if (field_flag_o !== ((m == 2'b01) ? 1'b0 : par)) flagbad++;
            end
            if (capture_o) begin
               ncap++; caplast = ln;
            end
         end
         hsync_i = 1'b0; osc_tick_i = 1'b0;
         rq = (m[1] == 1'b0) ? "R1" : (m == 2'b10) ? "R2" : "R3";
         check(first == expl, {rq, " pulse line"}, first, expl);
         check(npulse == ((expl != 0) ? 1 : 0), "R5 pulse lasts one line", npulse, (expl != 0) ? 1 : 0);
         check(ncap == npulse && (expl == 0 || caplast == expl + 1), "R6 capture at fall",
               caplast, (expl != 0) ? expl + 1 : 0);
         check(flagbad == 0, "R7 field flag during pulse", flagbad, 0);
         check(refsum == ((m == 2'b01) ? 25 : 0), "R9 reference pulse count", refsum, (m == 2'b01) ? 25 : 0);
      end

      // coincident vsync and hsync
      mode_i = 2'b10;
      @(negedge clk);
      do_vsync(1'b0);
      hs_ticks(19);
      vsync_i = 1'b1; hsync_i = 1'b1;
      @(negedge clk);
      vsync_i = 1'b0; hsync_i = 1'b0;
      hs_ticks(19);
      check(!line_pulse_o, "R4 coincident vsync wins (line 20)", line_pulse_o, 0);
      hs_ticks(1);
      check(line_pulse_o, "R4 coincident vsync wins (line 21)", line_pulse_o, 1);

      // vsync cuts the pulse short: flag held for that cycle
      do_vsync(1'b1);
      @(negedge clk);
      hs_ticks(20);
      check(line_pulse_o && field_flag_o, "R8 pulse high with even flag",
            {line_pulse_o, field_flag_o}, 3);
      vsync_i = 1'b1; field_even_i = 1'b0;
      @(negedge clk);
      vsync_i = 1'b0;
      check(!line_pulse_o && capture_o, "R6 capture on vsync-ended pulse",
            {line_pulse_o, capture_o}, 1);
      check(field_flag_o == 1'b1, "R8 flag stable at falling edge", field_flag_o, 1);
      @(negedge clk);
      check(field_flag_o == 1'b0, "R7 flag follows new parity", field_flag_o, 0);
      check(!capture_o, "R6 capture lasts one cycle", capture_o, 0);

      // field flag per mode after an odd/even vsync
      mode_i = 2'b00;
      do_vsync(1'b1); @(negedge clk);
      check(field_flag_o == 1'b1, "R7 mode 00 flag even", field_flag_o, 1);
      mode_i = 2'b01;
      @(negedge clk);
      check(field_flag_o == 1'b0, "R7 mode 01 flag forced low", field_flag_o, 0);

      // mode 01 ignores hsync entirely
      do_vsync(1'b1);
      begin
         int seen = 0;
         for (int k = 0; k < 30; k++) begin
            hsync_i = 1'b1; @(negedge clk);
            seen += int'(line_pulse_o) + int'(capture_o);
         end
         hsync_i = 1'b0;
         check(seen == 0, "R9 hsync ignored in mode 01", seen, 0);
      end

      // saturation: no wrap without vsync
      mode_i = 2'b10;
      @(negedge clk);
      do_vsync(1'b0);
      begin
         int seen = 0;
         for (int k = 0; k < 1100; k++) begin
            hsync_i = 1'b1; @(negedge clk);
            if (k >= 25) seen += int'(line_pulse_o);
         end
         hsync_i = 1'b0;
         check(seen == 0, "R10 no pulse after saturation", seen, 0);
      end
      do_vsync(1'b0);
      hs_ticks(20);
      check(line_pulse_o, "R10 recovers after vsync", line_pulse_o, 1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule